// File: doc/BRIEF.md
# PWM Timer with Event Action Generator

This block is a PWM time base with two driven outputs. A prescaler turns the module clock into timer ticks. On each tick a 16-bit counter steps up, down or up-then-down between zero and a programmable period. The counter value is compared against zero, the period and two compare values, and each match is an event. For each output, a table of 2-bit action codes decides what every event does to the output level. The code can leave the level alone, drive it low, drive it high or invert it. Each event has one entry for the rising count direction and another for the falling one.

Software programs the block through a simple register write port. An external sync pulse can place a chosen phase value into the counter, which keeps several timers aligned. Period and compare writes land in shadow registers. They reach the comparators only at a counter zero tick, or at once while the timer is stopped, so a running waveform never sees a half-updated cycle.

Top module: `pwm_action_gen`

## Requirements
- R1: With prescale value P (register address 1, bits 7:0), the counter moves at most once every P+1 clock cycles while running.
- R2: Count mode 1 (control register address 0, bits 1:0) counts up from 0 to the active period, then returns to 0 on the next tick.
- R3: Count mode 2 counts down to 0, then reloads the active period on the next tick.
- R4: Count mode 3 counts up until the counter reaches the period, then counts down until it reaches 0, reversing direction at each end. A zero or period event takes the direction that was in effect when it was reached.
- R5: Mode 0, or a clear run bit (control bit 2), freezes the counter and the prescaler. Both outputs then hold their levels.
- R6: When the sync enable bit (control bit 3) is set, a high sync_in at a clock edge loads the phase register (address 5) into the counter and applies no actions at that edge. When the enable bit is clear, sync_in has no effect.
- R7: Action codes: 0 leaves the level unchanged, 1 drives it low, 2 drives it high and 3 inverts it. An output changes only at a tick that is not overridden by sync.
- R8: Action tables sit at address 6 (output A) and address 7 (output B). The field for event e and direction d is at bits 4e+2d+1:4e+2d, where zero is e=0, period is e=1, compare A is e=2, compare B is e=3, and d=0 is up and d=1 is down.
- R9: When several events coincide on one tick, the field applied is the first non-zero one in the order compare B, compare A, period, zero.
- R10: Writes to the period (address 2), compare A (address 3) and compare B (address 4) registers take effect at a tick where the counter is 0, or on the next cycle while the timer is stopped. The tick that reloads them still uses the old values.
- R11: After reset, both outputs are low, the counter is 0 and every register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| sync_in | input | 1 | Counter phase reload request |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
Directed runs use each count mode with small periods and slow and fast prescale values. These separate the wrap, reload and turn-around points from one another. Coinciding compare values, and compares placed on zero or on the period, tell apart whether the priority order or a later event wins. Mid-run period and compare writes show whether a shadow value leaks in before the zero tick. Sync pulses sent with the enable set and with it clear expose a phase load that ignores the enable. Random configurations then draw every action code, direction field and mode, with occasional sync pulses and stops, and compare both outputs on every cycle against an independent model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Counter stepping modes as seen in control bits 1:0
  typedef enum logic [1:0] {
    MODE_HOLD   = 2'd0,
    MODE_UP     = 2'd1,
    MODE_DOWN   = 2'd2,
    MODE_UPDOWN = 2'd3
  } cnt_mode_e;

  // Output action codes
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  // Events by code: zero=0, period=1, cmpa=2, cmpb=3 (struct packs msb first)
  typedef struct packed {
    logic cmpb;
    logic cmpa;
    logic period;
    logic zero;
  } events_t;

  localparam int N_EVT    = 4;
  localparam int ACT_BITS = 2;
  localparam int TBL_W    = N_EVT * 2 * ACT_BITS;

  // Register addresses
  localparam int REG_CTRL  = 0;
  localparam int REG_PRE   = 1;
  localparam int REG_PER   = 2;
  localparam int REG_CMPA  = 3;
  localparam int REG_CMPB  = 4;
  localparam int REG_PHASE = 5;
  localparam int REG_TBL_A = 6;
  localparam int REG_TBL_B = 7;

  // Highest-priority non-keep action among the events present this tick.
  // Walks events from lowest code upward so later (higher priority) wins.
  function automatic act_e pick_action(input logic [TBL_W-1:0] tbl,
                                       input logic down,
                                       input events_t ev);
    logic [N_EVT-1:0] hit;
    act_e cand;
    act_e sel;
    hit = ev;
    sel = ACT_KEEP;
    for (int e = 0; e < N_EVT; e++) begin
      cand = act_e'(tbl[e*2*ACT_BITS + (down ? ACT_BITS : 0) +: ACT_BITS]);
      if (hit[e] && cand != ACT_KEEP) sel = cand;
    end
    return sel;
  endfunction

  function automatic logic apply_action(input logic lvl, input act_e a);
    case (a)
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_FLIP: return ~lvl;
      default:  return lvl;
    endcase
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_act,
  output cnt_mode_e         mode,
  output logic              run_en,
  output logic              sync_en,
  output logic [PS_W-1:0]   prescale,
  output logic [CNT_W-1:0]  phase,
  output logic [CNT_W-1:0]  period_act,
  output logic [CNT_W-1:0]  cmpa_act,
  output logic [CNT_W-1:0]  cmpb_act,
  output logic [TBL_W-1:0]  tbl_a,
  output logic [TBL_W-1:0]  tbl_b
);

  logic [CNT_W-1:0] period_sh, cmpa_sh, cmpb_sh;

  // Programmed registers and shadows
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_HOLD;
      run_en    <= 1'b0;
      sync_en   <= 1'b0;
      prescale  <= '0;
      phase     <= '0;
      period_sh <= '0;
      cmpa_sh   <= '0;
      cmpb_sh   <= '0;
      tbl_a     <= '0;
      tbl_b     <= '0;
    end else if (wr_en) begin
      case (int'(wr_addr))
        REG_CTRL: begin
          mode    <= cnt_mode_e'(wr_data[1:0]);
          run_en  <= wr_data[2];
          sync_en <= wr_data[3];
        end
        REG_PRE:   prescale  <= wr_data[PS_W-1:0];
        REG_PER:   period_sh <= wr_data[CNT_W-1:0];
        REG_CMPA:  cmpa_sh   <= wr_data[CNT_W-1:0];
        REG_CMPB:  cmpb_sh   <= wr_data[CNT_W-1:0];
        REG_PHASE: phase     <= wr_data[CNT_W-1:0];
        REG_TBL_A: tbl_a     <= wr_data[TBL_W-1:0];
        REG_TBL_B: tbl_b     <= wr_data[TBL_W-1:0];
        default: ;
      endcase
    end
  end

  // Active copies seen by the comparators
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_act <= '0;
      cmpa_act   <= '0;
      cmpb_act   <= '0;
    end else if (load_act) begin
      period_act <= period_sh;
      cmpa_act   <= cmpa_sh;
      cmpb_act   <= cmpb_sh;
    end
  end

endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            running,
  input  logic            restart,
  input  logic [PS_W-1:0] prescale,
  output logic            tick
);

  logic [PS_W-1:0] div_q;

  assign tick = running && (div_q >= prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (!running || restart) div_q <= '0;
    else if (tick)             div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sync_hit,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] cmpb,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_down,
  output events_t          ev
);

  logic             dir_q;
  logic [CNT_W:0]   nxt;

  // Returns {direction_down, next_count} for one timer tick
  function automatic logic [CNT_W:0] advance(input cnt_mode_e m,
                                             input logic dn,
                                             input logic [CNT_W-1:0] c,
                                             input logic [CNT_W-1:0] top);
    logic             d;
    logic [CNT_W-1:0] n;
    d = dn;
    n = c;
    case (m)
      MODE_UP:   n = (c >= top) ? '0 : c + 1'b1;
      MODE_DOWN: n = (c == '0) ? top : c - 1'b1;
      MODE_UPDOWN: begin
        if (!dn) begin
          if (c >= top) begin
            d = 1'b1;
            n = (c == '0) ? '0 : c - 1'b1;
          end else begin
            n = c + 1'b1;
          end
        end else begin
          if (c == '0) begin
            d = 1'b0;
            n = (top == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
          end else begin
            n = c - 1'b1;
          end
        end
      end
      default: ;
    endcase
    return {d, n};
  endfunction

  assign cnt_down = (mode == MODE_DOWN) || (mode == MODE_UPDOWN && dir_q);
  assign nxt      = advance(mode, dir_q, cnt, period);

  assign ev.zero   = (cnt == '0);
  assign ev.period = (cnt == period);
  assign ev.cmpa   = (cnt == cmpa);
  assign ev.cmpb   = (cnt == cmpb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= 1'b0;
    end else if (sync_hit) begin
      cnt <= phase;
    end else if (step) begin
      cnt <= nxt[CNT_W-1:0];
      if (mode == MODE_UPDOWN) dir_q <= nxt[CNT_W];
    end
  end

endmodule

// File: rtl/pwm_out_gen.sv
module pwm_out_gen
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  events_t          ev,
  input  logic [TBL_W-1:0] tbl,
  output logic             lvl
);

  act_e act;

  assign act = pick_action(tbl, down, ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl <= 1'b0;
    else if (step) lvl <= apply_action(lvl, act);
  end

endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sync_in,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam int N_OUT = 2;

  cnt_mode_e        mode;
  logic             run_en, sync_en;
  logic [PS_W-1:0]  prescale;
  logic [CNT_W-1:0] phase, period_act, cmpa_act, cmpb_act, cnt;
  logic [TBL_W-1:0] tbl [N_OUT];
  logic [N_OUT-1:0] lvl;
  events_t          ev;

  // Named internal events
  logic running, sync_hit, tick, step, load_act, cnt_down;

  assign running  = run_en && (mode != MODE_HOLD);
  assign sync_hit = sync_in && sync_en;
  assign step     = tick && !sync_hit;
  assign load_act = !running || (step && ev.zero);

  pwm_regs #(
    .CNT_W(CNT_W), .PS_W(PS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_act(load_act),
    .mode(mode), .run_en(run_en), .sync_en(sync_en),
    .prescale(prescale), .phase(phase),
    .period_act(period_act), .cmpa_act(cmpa_act), .cmpb_act(cmpb_act),
    .tbl_a(tbl[0]), .tbl_b(tbl[1])
  );

  pwm_tick_gen #(.PS_W(PS_W)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .running(running), .restart(sync_hit),
    .prescale(prescale), .tick(tick)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .step(step), .sync_hit(sync_hit), .mode(mode),
    .phase(phase), .period(period_act), .cmpa(cmpa_act), .cmpb(cmpb_act),
    .cnt(cnt), .cnt_down(cnt_down), .ev(ev)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    pwm_out_gen u_gen (
      .clk(clk), .rst_n(rst_n),
      .step(step), .down(cnt_down), .ev(ev),
      .tbl(tbl[i]), .lvl(lvl[i])
    );
  end

  assign pwm_a = lvl[0];
  assign pwm_b = lvl[1];

endmodule

// File: rtl/pwm_action_gen_chk.sv
module pwm_action_gen_chk
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             tick,
  input logic             step,
  input logic             sync_hit,
  input logic             running,
  input logic [PS_W-1:0]  prescale,
  input cnt_mode_e        mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period_act,
  input logic [CNT_W-1:0] phase,
  input logic             cnt_down,
  input logic             pwm_a,
  input logic             pwm_b
);

  // R1: with a non-zero prescale two ticks are never adjacent
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && prescale != '0 && !wr_en |=> !tick);

  // R2: up mode below the period steps by one
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == MODE_UP && cnt < period_act |=> cnt == $past(cnt) + 1'b1);

  // R3: down mode reloads the period after zero
  a_r3_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == MODE_DOWN && cnt == '0 |=> cnt == $past(period_act));

  // R4: up-down mode turns around at the period
  a_r4_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
    step && !wr_en && mode == MODE_UPDOWN && !cnt_down && cnt >= period_act
    && period_act != '0 |=> cnt_down);

  // R5: a stopped timer keeps its count
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !sync_hit |=> $stable(cnt));

  // R6: an accepted sync loads the phase
  a_r6_phase_load: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> cnt == $past(phase));

  // R7: outputs move only on an applied tick
  a_r7_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pwm_a) && $stable(pwm_b));

endmodule

bind pwm_action_gen pwm_action_gen_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .step(step),
  .sync_hit(sync_hit), .running(running), .prescale(prescale), .mode(mode),
  .cnt(cnt), .period_act(period_act), .phase(phase), .cnt_down(cnt_down),
  .pwm_a(pwm_a), .pwm_b(pwm_b)
);

// File: tb/pwm_action_gen_test.sv
`timescale 1ns/1ps
module pwm_action_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        sync_in;
  logic        pwm_a, pwm_b;

  int n_chk = 0;
  int n_fail = 0;
  string cur = "R11";
  logic checking = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_action_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // ---------------- reference model, written from the requirements --------
  logic [1:0]  m_mode;
  logic        m_run, m_sen, m_dir, m_a, m_b;
  logic [7:0]  m_ps, m_pre;
  logic [15:0] m_ph, s_per, s_ca, s_cb, a_per, a_ca, a_cb, m_cnt, m_ta, m_tb;

  // field for event code ev (zero 0, period 1, cmpA 2, cmpB 3), direction dn
  function automatic logic [1:0] fld(input logic [15:0] t, input int ev, input logic dn);
    return t[ev*4 + (dn ? 2 : 0) +: 2];
  endfunction

  function automatic logic next_lvl(input logic lvl, input logic [15:0] t, input logic dn,
                                    input logic z, input logic p, input logic ca, input logic cb);
    logic [1:0] f;
    f = 2'd0;
    if (cb && fld(t, 3, dn) != 2'd0)      f = fld(t, 3, dn);
    else if (ca && fld(t, 2, dn) != 2'd0) f = fld(t, 2, dn);
    else if (p && fld(t, 1, dn) != 2'd0)  f = fld(t, 1, dn);
    else if (z && fld(t, 0, dn) != 2'd0)  f = fld(t, 0, dn);
    case (f)
      2'd1: return 1'b0;
      2'd2: return 1'b1;
      2'd3: return !lvl;
      default: return lvl;
    endcase
  endfunction

  function automatic logic [15:0] tbl(input logic [1:0] zu, input logic [1:0] zd,
                                      input logic [1:0] pu, input logic [1:0] pd,
                                      input logic [1:0] au, input logic [1:0] ad,
                                      input logic [1:0] bu, input logic [1:0] bd);
    return {bd, bu, ad, au, pd, pu, zd, zu};
  endfunction

  always @(posedge clk) begin
    logic live, sh, tk, st, dn, ld;
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_sen = 0; m_dir = 0; m_a = 0; m_b = 0;
      m_ps = 0; m_pre = 0; m_ph = 0; s_per = 0; s_ca = 0; s_cb = 0;
      a_per = 0; a_ca = 0; a_cb = 0; m_cnt = 0; m_ta = 0; m_tb = 0;
    end else begin
      live = m_run && (m_mode != 2'd0);
      sh   = sync_in && m_sen;
      tk   = live && (m_pre >= m_ps);
      st   = tk && !sh;
      dn   = (m_mode == 2'd2) || (m_mode == 2'd3 && m_dir);
      ld   = !live || (st && m_cnt == 16'd0);
      if (st) begin
        m_a = next_lvl(m_a, m_ta, dn, m_cnt == 0, m_cnt == a_per, m_cnt == a_ca, m_cnt == a_cb);
        m_b = next_lvl(m_b, m_tb, dn, m_cnt == 0, m_cnt == a_per, m_cnt == a_ca, m_cnt == a_cb);
        if (m_mode == 2'd1) begin
          if (m_cnt >= a_per) m_cnt = 0; else m_cnt = m_cnt + 1;
        end else if (m_mode == 2'd2) begin
          if (m_cnt == 0) m_cnt = a_per; else m_cnt = m_cnt - 1;
        end else if (m_mode == 2'd3) begin
          if (!m_dir) begin
            if (m_cnt >= a_per) begin
              m_dir = 1;
              if (m_cnt != 0) m_cnt = m_cnt - 1;
            end else m_cnt = m_cnt + 1;
          end else if (m_cnt == 0) begin
            m_dir = 0;
            if (a_per != 0) m_cnt = 1;
          end else m_cnt = m_cnt - 1;
        end
      end
      if (sh) m_cnt = m_ph;
      if (!live || sh || tk) m_pre = 0; else m_pre = m_pre + 1;
      if (ld) begin a_per = s_per; a_ca = s_ca; a_cb = s_cb; end
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = wr_data[1:0]; m_run = wr_data[2]; m_sen = wr_data[3]; end
          3'd1: m_ps  = wr_data[7:0];
          3'd2: s_per = wr_data;
          3'd3: s_ca  = wr_data;
          3'd4: s_cb  = wr_data;
          3'd5: m_ph  = wr_data;
          3'd6: m_ta  = wr_data;
          default: m_tb = wr_data;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk(cur, "pwm_a", pwm_a, m_a);
      chk(cur, "pwm_b", pwm_b, m_b);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [1:0] mode, input logic sen, input logic [7:0] ps,
                       input logic [15:0] per, input logic [15:0] ca, input logic [15:0] cb,
                       input logic [15:0] ph, input logic [15:0] ta, input logic [15:0] tb);
    wr(3'd0, 16'd0);
    wr(3'd1, {8'd0, ps});
    wr(3'd2, per);
    wr(3'd3, ca);
    wr(3'd4, cb);
    wr(3'd5, ph);
    wr(3'd6, ta);
    wr(3'd7, tb);
    wr(3'd0, {12'd0, sen, 1'b1, mode});
  endtask

  task automatic pulse_sync();
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sync_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset levels
    chk("R11", "pwm_a after reset", pwm_a, 1'b0);
    chk("R11", "pwm_b after reset", pwm_b, 1'b0);
    checking = 1'b1;

    // R2: up counting, zero sets A high, cmpA up clears it, period toggles B
    cur = "R2";
    setup(2'd1, 1'b0, 8'd0, 16'd9, 16'd5, 16'd200, 16'd0,
          tbl(2, 0, 0, 0, 1, 0, 0, 0), tbl(0, 0, 3, 0, 0, 0, 0, 0));
    idle(60);

    // R1: same waveform stretched by the prescaler
    cur = "R1";
    wr(3'd0, 16'd0);
    wr(3'd1, 16'd3);
    wr(3'd0, 16'h0005);
    idle(150);

    // R3: down counting with down-direction fields
    cur = "R3";
    setup(2'd2, 1'b0, 8'd1, 16'd7, 16'd3, 16'd200, 16'd0,
          tbl(0, 3, 0, 0, 0, 2, 0, 0), tbl(0, 1, 0, 2, 0, 0, 0, 0));
    idle(80);

    // R4: up-down with period-up and zero-down fields
    cur = "R4";
    setup(2'd3, 1'b0, 8'd0, 16'd6, 16'd2, 16'd200, 16'd0,
          tbl(0, 3, 3, 0, 0, 0, 0, 0), tbl(0, 0, 0, 0, 2, 1, 0, 0));
    idle(80);

    // R5: stop mid-cycle, then mode 0 with run set, then resume
    cur = "R5";
    idle(3);
    wr(3'd0, 16'h0003);
    idle(30);
    wr(3'd0, 16'h0004);
    idle(30);
    wr(3'd0, 16'h0007);
    idle(40);

    // R6: sync accepted, then ignored once the enable is cleared
    cur = "R6";
    setup(2'd1, 1'b1, 8'd0, 16'd20, 16'd16, 16'd3, 16'd15,
          tbl(2, 0, 0, 0, 3, 0, 1, 0), tbl(0, 0, 0, 0, 0, 0, 3, 0));
    idle(7);
    pulse_sync();
    idle(5);
    pulse_sync();
    idle(30);
    wr(3'd0, 16'h0005);
    idle(4);
    pulse_sync();
    idle(10);
    pulse_sync();
    idle(30);

    // R9: coinciding events resolved by priority
    cur = "R9";
    setup(2'd1, 1'b0, 8'd0, 16'd10, 16'd4, 16'd4, 16'd0,
          tbl(0, 0, 1, 0, 1, 0, 2, 0), tbl(2, 0, 1, 0, 3, 0, 0, 0));
    idle(50);
    wr(3'd0, 16'd0);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd10);
    wr(3'd6, tbl(2, 0, 2, 0, 1, 0, 3, 0));
    wr(3'd0, 16'h0005);
    idle(50);

    // R10: shadow period and compare writes while running
    cur = "R10";
    setup(2'd1, 1'b0, 8'd0, 16'd9, 16'd5, 16'd7, 16'd0,
          tbl(2, 0, 0, 0, 1, 0, 0, 0), tbl(0, 0, 0, 0, 0, 0, 3, 0));
    idle(13);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd2);
    idle(6);
    wr(3'd4, 16'd1);
    idle(40);

    // R7 and R8: random configurations over all codes, fields and modes
    for (int s = 0; s < 40; s++) begin
      logic [15:0] per;
      cur = (s % 2 == 0) ? "R7" : "R8";
      per = 16'($urandom_range(0, 24));
      setup(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            8'($urandom_range(0, 3)), per,
            16'($urandom_range(0, int'(per) + 2)), 16'($urandom_range(0, int'(per) + 2)),
            16'($urandom_range(0, 30)), 16'($urandom), 16'($urandom));
      for (int c = 0; c < 200; c++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 2) pulse_sync();
        else if (r == 2) wr(3'd3, 16'($urandom_range(0, int'(per) + 1)));
        else if (r == 3) wr(3'd2, 16'($urandom_range(0, 24)));
        else @(negedge clk);
      end
    end

    checking = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule